// File: doc/BRIEF.md
# Sine Tone Synthesizer with One-Bit Pulse-Density Output

The block makes an audio-range sine tone from one system clock and sends it out as a single pin. A 22-bit phase accumulator grows by an unsigned 8-bit step word on every clock. A step word of zero holds the phase where it is, so the tone stops.

The top 8 bits of the phase select one of 256 entries in a sine table. The table spans one full period and uses only codes 28 through 228. The chosen code feeds a first-order sigma-delta modulator that runs at the full clock rate. Its carry bit forms a pulse stream whose density of ones equals code/256. An off-chip low-pass filter turns this stream into audio.

The tone frequency is f_clk × step / 2^22. At 32 MHz this gives about 7.6 Hz for step 1 and just under 2 kHz for step 255. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `tone_synth`

## Requirements
- R1: While reset is asserted the pulse output is 0. After reset the phase and the modulator sum are zero, and the sample register holds table entry 0 (code 128).
- R2: On every clock the phase accumulator adds the step word, modulo 2^22.
- R3: A step word of zero leaves the phase unchanged, so the pulse density stays constant for as long as the step is zero.
- R4: The table address is phase bits 21 down to 14, so phase value a·2^14 selects entry a.
- R5: Table entry a equals round(128 + 100·sin(2πa/256)) within one code, and every entry lies in 28..228.
- R6: Each clock the 9-bit sum becomes its low 8 bits plus the sample. The output is sum bit 8, so any 256-clock window of a held sample contains exactly that sample's value in ones.
- R7: The table read has one clock of latency: when the address is steady, the sample is steady one clock later.
- R8: With step s where s divides 2^22, the phase returns to its starting value after 2^22/s clocks, which restores the same table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the modulator runs at this rate |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_i | input | 8 | Unsigned phase increment per clock; zero mutes |
| pulse_o | output | 1 | Pulse-density output stream |

## Verification
The bench builds the block with its default parameters: a 22-bit phase, 8-bit step, address and sample, and codes 28..228. This keeps a walk over the table within reach. The bench steers the phase to every even table address by applying chosen step words, then sets the step to zero to freeze it. It then counts ones over 256 clocks and compares the count with an arithmetic sine value, which tests the address slicing, the table contents and the exact modulator density together. A full wrap at step 128 (32768 clocks) confirms the accumulator modulus, and the reset window plus the address-0 density confirm the reset state.

// File: rtl/tone_pkg.sv
package tone_pkg;

  // Integer sine approximation (rational form) used to build the table.
  // Returns mid + amp*sin(2*pi*idx/2^addr_w), rounded, where mid and amp
  // are derived from the lowest and highest code.
  function automatic int sine_code(input int idx, input int addr_w,
                                   input int lo, input int hi);
    int half;
    int t;
    int p;
    int num;
    int den;
    int v;
    int mid;
    int amp;
    half = 1 << (addr_w - 1);
    mid  = (lo + hi) / 2;
    amp  = (hi - lo) / 2;
    t    = idx % half;
    p    = t * (half - t);
    num  = 16 * p * amp;
    den  = 5 * half * half - 4 * p;
    v    = (num + den / 2) / den;
    if (idx < half) return mid + v;
    else            return mid - v;
  endfunction

endpackage

// File: rtl/tone_rst_sync.sv
module tone_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/tone_phase_acc.sv
module tone_phase_acc #(
  parameter int PHASE_W = 22,
  parameter int STEP_W  = 8,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] step_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int TOP_BIT = PHASE_W - 1;

  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] phase_d;
  logic               adv_en;

  always_comb begin
    adv_en  = (step_i != '0);
    phase_d = phase_q + PHASE_W'(step_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= '0;
    else if (adv_en) phase_q <= phase_d;
  end

  assign addr_o = phase_q[TOP_BIT -: ADDR_W];

  AST_PHASE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == '0) |=> $stable(phase_q)) else $error("phase moved at zero step"); // R3

  AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i != '0) |=> (phase_q != $past(phase_q))) else $error("phase did not advance"); // R2

endmodule

// File: rtl/tone_wave_rom.sv
module tone_wave_rom #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int LO_CODE = 28,
  parameter int HI_CODE = 228
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] RST_CODE =
    DATA_W'(tone_pkg::sine_code(0, ADDR_W, LO_CODE, HI_CODE));

  logic [DATA_W-1:0] table_w [DEPTH];
  logic [DATA_W-1:0] data_d;
  logic [DATA_W-1:0] data_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign table_w[i] = DATA_W'(tone_pkg::sine_code(i, ADDR_W, LO_CODE, HI_CODE));
  end

  always_comb begin
    data_d = table_w[addr_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= RST_CODE;
    else        data_q <= data_d;
  end

  assign data_o = data_q;

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_q >= DATA_W'(LO_CODE)) && (data_q <= DATA_W'(HI_CODE))) else $error("code out of range"); // R5

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(addr_i) |=> $stable(data_q)) else $error("sample moved with steady address"); // R7

endmodule

// File: rtl/tone_sd_mod.sv
module tone_sd_mod #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] sample_i,
  output logic              pulse_o
);

  logic [DATA_W:0] sum_q;
  logic [DATA_W:0] sum_d;

  always_comb begin
    sum_d = {1'b0, sum_q[DATA_W-1:0]} + {1'b0, sample_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

  assign pulse_o = sum_q[DATA_W];

  // A carry means the residue wrapped, so it must now be below the sample added.
  AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> (sum_q[DATA_W-1:0] < $past(sample_i))) else $error("carry without wrap"); // R6

  AST_NO_CARRY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sample_i) == '0) |-> !pulse_o) else $error("carry from zero sample"); // R6

endmodule

// File: rtl/tone_synth.sv
module tone_synth #(
  parameter int PHASE_W    = 22,
  parameter int STEP_W     = 8,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int LO_CODE    = 28,
  parameter int HI_CODE    = 228,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [STEP_W-1:0] step_i,
  output logic              pulse_o
);

  logic              rst_n;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] sample;

  tone_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  tone_phase_acc #(.PHASE_W(PHASE_W), .STEP_W(STEP_W), .ADDR_W(ADDR_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (step_i),
    .addr_o (addr)
  );

  tone_wave_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .LO_CODE(LO_CODE), .HI_CODE(HI_CODE)) u_rom (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr_i (addr),
    .data_o (sample)
  );

  tone_sd_mod #(.DATA_W(DATA_W)) u_sd (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_i (sample),
    .pulse_o  (pulse_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!arst_n)
    !rst_n |-> !pulse_o) else $error("pulse during reset"); // R1

endmodule

// File: tb/tone_synth_test.sv
module tone_synth_test;

  logic       clk = 1'b0;
  logic       arst_n;
  logic [7:0] step;
  logic       pulse;

  int vectors = 0;
  int misses  = 0;
  int phase   = 0;

  always #10 clk = ~clk;

  tone_synth uut (
    .clk     (clk),
    .arst_n  (arst_n),
    .step_i  (step),
    .pulse_o (pulse)
  );

  function automatic int exp_code(input int a);
    real x;
    x = 128.0 + 100.0 * $sin(2.0 * 3.14159265358979 * real'(a) / 256.0);
    return $rtoi(x + 0.5);
  endfunction

  task automatic check(input string req, input int act, input int exp, input int tol);
    int d;
    vectors++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d (tol %0d)", req, act, exp, tol);
    end
  endtask

  // Move the phase forward by delta, then freeze it with a zero step.
  task automatic advance(input int delta);
    int q;
    int r;
    q = delta / 255;
    r = delta % 255;
    if (q > 0) begin
      @(negedge clk) step = 8'd255;
      repeat (q) @(posedge clk);
    end
    if (r > 0) begin
      @(negedge clk) step = 8'(r);
      @(posedge clk);
    end
    @(negedge clk) step = 8'd0;
    phase = (phase + delta) % (1 << 22);
  endtask

  task automatic measure(output int ones);
    repeat (4) @(posedge clk);
    ones = 0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      ones += int'(pulse);
    end
  endtask

  initial begin
    #(20 * 190000);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    int ones;
    int first;
    int peak;
    arst_n = 1'b0;
    step   = 8'd0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R1 pulse low in reset", int'(pulse), 0, 0);
    end
    @(negedge clk) arst_n = 1'b1;
    repeat (4) @(posedge clk);

    measure(ones);
    check("R1 density after reset (entry 0)", ones, 128, 0);
    first = ones;
    measure(ones);
    check("R3 zero step holds density", ones, first, 0);

    // Walk every even table address; R4 address slicing, R5 table, R6 density, R7 latency
    for (int a = 2; a < 256; a += 2) begin
      advance(2 << 14);
      measure(ones);
      check($sformatf("R5 R6 R4 R7 entry %0d", a), ones, exp_code(a), 1);
      check($sformatf("R5 range low entry %0d", a), (ones >= 28) ? 1 : 0, 1, 0);
      check($sformatf("R5 range high entry %0d", a), (ones <= 228) ? 1 : 0, 1, 0);
    end

    // Wrap through 2^22 back to address 0
    advance(2 << 14);
    measure(ones);
    check("R2 accumulator wraps modulo 2^22", ones, 128, 0);

    // Peak at address 64
    advance(64 << 14);
    measure(peak);
    check("R5 peak entry 64", peak, 228, 1);

    // Full period at step 128: 32768 clocks
    @(negedge clk) step = 8'd128;
    repeat (32768) @(posedge clk);
    @(negedge clk) step = 8'd0;
    measure(ones);
    check("R8 period 2^22/128 restores entry", ones, peak, 0);
    measure(ones);
    check("R3 mute after wrap", ones, peak, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule